// File: doc/BRIEF.md
# Width-Selectable Byte FIFO for a Serial Shifter

This block is one direction of the data buffer that sits between a word-oriented producer (register writes or a DMA engine) and a serial shifter. Its storage is a fixed number of bytes. A control field picks the entry size: 1, 2 or 4 bytes. So the same storage holds 256 single-byte entries, 128 halfword entries or 64 word entries. Each push stores the low bytes of the 32-bit input. Each pop returns the oldest entry, zero-extended to 32 bits.

Software runs the buffer through an operation register. One bit holds it in reset, which clears the pointers and discards the contents. Another bit starts it. Writing zero stops it, and the contents are kept. The status word reports:
- the fill level in bytes, saturating at 255;
- a full flag;
- an empty flag.

A programmed byte threshold drives a threshold-reached output. A parameter fixes the comparison direction: at or above the threshold for a receive buffer, at or below it for a transmit buffer. A separate check register holds three watermarks in 4-byte units. Each watermark drives its own output.

Top module: `spi_byte_fifo`

## Requirements
- R1: After reset the buffer is stopped, the level is 0, the empty flag (status bit 9) is 1, the full flag (status bit 8) is 0, and err_o is 0.
- R2: The operation word acts as follows: bit 0 set holds the buffer in reset and clears its level; only the value 2'b10 (bit 1 set, bit 0 clear) runs it. While the buffer is stopped or in reset, pushes and pops change nothing and raise no error.
- R3: Control bits 1:0 select the entry size: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes. The buffer accepts exactly CAP_BYTES / size entries before it reports full.
- R4: Pops return entries in push order. Each entry carries the low size bytes of push_data_i, little-endian, and its upper bytes read as zero.
- R5: Status bits 7:0 hold the level in bytes and saturate at 255 when the level is 256. Bit 8 is set when another entry would not fit (level > CAP_BYTES - size). Bit 9 is set when the level is 0. Bits 8 and 9 are never set together.
- R6: A push while full or a pop with fewer bytes than one entry is ignored. It sets err_o for exactly one cycle, starting on the edge that follows the request.
- R7: The threshold is held in control bits 9:2. With RX_DIR=1, thr_o is set while level >= threshold. With RX_DIR=0, thr_o is set while level <= threshold.
- R8: The check word holds three 6-bit watermarks, at bits 5:0, 15:10 and 25:20. wm_o[k] is set while level/4 >= watermark k.
- R9: A push and a pop in the same cycle, when both are legal, leave the level unchanged, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_we_i | input | 1 | Operation word write strobe |
| op_wdata_i | input | 2 | Operation word: bit 0 reset, bit 1 start |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 10 | Control word: size in bits 1:0, threshold in bits 9:2 |
| chk_we_i | input | 1 | Check word write strobe |
| chk_wdata_i | input | 26 | Three watermarks at bits 5:0, 15:10 and 25:20 |
| push_i | input | 1 | Push request |
| push_data_i | input | 32 | Push data; the low size bytes are stored |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | 32 | Oldest entry, zero-extended |
| status_o | output | 10 | Level in bits 7:0, full in bit 8, empty in bit 9 |
| thr_o | output | 1 | Threshold reached |
| wm_o | output | 3 | Watermark reached, one bit per watermark |
| err_o | output | 1 | One-cycle overflow or underflow pulse |

## Verification
The assertions assume that push_i, pop_i and the write strobes are never X after reset. They also assume that the entry size is not changed while entries are held, because the level is kept in bytes and a size change would leave partial entries. The stimulus follows both rules: it flushes and restarts the buffer before every size change, and it drives every input on the falling edge from a defined value.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int LANES = 4;
  localparam int WM_NUM = 3;
  localparam int WM_W = 6;
  localparam int THR_W = 8;
  localparam int LVL_W = 8;

  typedef enum logic [1:0] {
    ENT_BYTE = 2'd0,
    ENT_HALF = 2'd1,
    ENT_WORD = 2'd2
  } ent_w_e;

  function automatic logic [2:0] ent_bytes(input logic [1:0] w);
    case (w)
      ENT_BYTE: return 3'd1;
      ENT_HALF: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/spi_fifo_cfg.sv
module spi_fifo_cfg
  import spi_fifo_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          op_we_i,
  input  logic [1:0]                    op_wdata_i,
  input  logic                          ctrl_we_i,
  input  logic [THR_W+1:0]              ctrl_wdata_i,
  input  logic                          chk_we_i,
  input  logic [25:0]                   chk_wdata_i,
  output logic                          clr_o,
  output logic                          act_o,
  output logic [2:0]                    ebytes_o,
  output logic [THR_W-1:0]              thr_o,
  output logic [WM_NUM-1:0][WM_W-1:0]   wm_o
);
  localparam int WM_STRIDE = 10;

  logic [1:0]       op_q;
  logic [1:0]       wsel_q;
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= 2'b00;
      wsel_q <= ENT_BYTE;
      thr_q  <= '0;
    end else begin
      if (op_we_i)   op_q <= op_wdata_i;
      if (ctrl_we_i) begin
        wsel_q <= ctrl_wdata_i[1:0];
        thr_q  <= ctrl_wdata_i[THR_W+1:2];
      end
    end
  end

  for (genvar k = 0; k < WM_NUM; k++) begin : g_wm
    localparam int OFF = k * WM_STRIDE;
    logic [WM_W-1:0] f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= '0;
      else if (chk_we_i) f_q <= chk_wdata_i[OFF +: WM_W];
    end
    assign wm_o[k] = f_q;
  end

  assign clr_o    = op_q[0];
  assign act_o    = (op_q == 2'b10);
  assign ebytes_o = ent_bytes(wsel_q);
  assign thr_o    = thr_q;
endmodule

// File: rtl/spi_fifo_store.sv
module spi_fifo_store
  import spi_fifo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  localparam int AW = $clog2(CAP_BYTES),
  localparam int CW = AW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 act_i,
  input  logic [2:0]           ebytes_i,
  input  logic                 push_i,
  input  logic [8*LANES-1:0]   push_data_i,
  input  logic                 pop_i,
  output logic [8*LANES-1:0]   pop_data_o,
  output logic [CW-1:0]        lvl_o,
  output logic                 err_o
);
  logic [7:0]    mem_q [CAP_BYTES];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] lvl_q;
  logic          err_q;
  logic [CW-1:0] eb_c;
  logic          full_c, has_ent_c, do_push, do_pop;

  assign eb_c      = CW'(ebytes_i);
  assign full_c    = lvl_q > (CW'(CAP_BYTES) - eb_c);
  assign has_ent_c = lvl_q >= eb_c;
  assign do_push   = act_i & push_i & ~full_c;
  assign do_pop    = act_i & pop_i & has_ent_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= act_i & ((push_i & full_c) | (pop_i & ~has_ent_c));
      if (clr_i) begin
        wr_q  <= '0;
        rd_q  <= '0;
        lvl_q <= '0;
      end else begin
        if (do_push) wr_q <= wr_q + AW'(ebytes_i);
        if (do_pop)  rd_q <= rd_q + AW'(ebytes_i);
        lvl_q <= lvl_q + (do_push ? eb_c : '0) - (do_pop ? eb_c : '0);
      end
    end
  end

  // byte lanes land at consecutive addresses, wrapping modulo capacity
  always_ff @(posedge clk_i) begin
    if (do_push) begin
      for (int k = 0; k < LANES; k++) begin
        if (ebytes_i > 3'(k)) mem_q[wr_q + AW'(k)] <= push_data_i[8*k +: 8];
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    logic [AW-1:0] ra;
    assign ra = rd_q + AW'(k);
    assign pop_data_o[8*k +: 8] = (ebytes_i > 3'(k)) ? mem_q[ra] : 8'h00;
  end

  assign lvl_o = lvl_q;
  assign err_o = err_q;

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lvl_q == '0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !clr_i) |=> $stable(lvl_q)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= CW'(CAP_BYTES)); // R5
  AST_PAIR_KEEPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !clr_i && push_i && pop_i && lvl_q >= eb_c && lvl_q <= CW'(CAP_BYTES) - eb_c)
    |=> $stable(lvl_q)); // R9
endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import spi_fifo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter bit RX_DIR = 1'b1,
  localparam int CW = $clog2(CAP_BYTES) + 1
) (
  input  logic [CW-1:0]               lvl_i,
  input  logic [2:0]                  ebytes_i,
  input  logic [THR_W-1:0]            thr_i,
  input  logic [WM_NUM-1:0][WM_W-1:0] wm_i,
  output logic [LVL_W+1:0]            status_o,
  output logic                        thr_o,
  output logic [WM_NUM-1:0]           wm_o
);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic [LVL_W-1:0] lvl_sat;
  logic [CW-1:0]    lvl_units;

  assign lvl_sat   = (int'(lvl_i) > LVL_MAX) ? LVL_W'(LVL_MAX) : LVL_W'(lvl_i);
  assign lvl_units = lvl_i >> 2;
  assign status_o  = {(lvl_i == '0),
                      (int'(lvl_i) > CAP_BYTES - int'(ebytes_i)),
                      lvl_sat};

  if (RX_DIR) begin : g_rx
    assign thr_o = int'(lvl_i) >= int'(thr_i);
  end else begin : g_tx
    assign thr_o = int'(lvl_i) <= int'(thr_i);
  end

  for (genvar k = 0; k < WM_NUM; k++) begin : g_wm
    assign wm_o[k] = int'(lvl_units) >= int'(wm_i[k]);
  end
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_fifo_pkg::*;
#(
  parameter int CAP_BYTES = 256,
  parameter bit RX_DIR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_we_i,
  input  logic [1:0]   op_wdata_i,
  input  logic         ctrl_we_i,
  input  logic [9:0]   ctrl_wdata_i,
  input  logic         chk_we_i,
  input  logic [25:0]  chk_wdata_i,
  input  logic         push_i,
  input  logic [31:0]  push_data_i,
  input  logic         pop_i,
  output logic [31:0]  pop_data_o,
  output logic [9:0]   status_o,
  output logic         thr_o,
  output logic [2:0]   wm_o,
  output logic         err_o
);
  localparam int CW = $clog2(CAP_BYTES) + 1;

  logic                        clr, act;
  logic [2:0]                  ebytes;
  logic [THR_W-1:0]            thr;
  logic [WM_NUM-1:0][WM_W-1:0] wm_f;
  logic [CW-1:0]               lvl;

  spi_fifo_cfg u_cfg (
    .clk_i, .rst_ni,
    .op_we_i, .op_wdata_i,
    .ctrl_we_i, .ctrl_wdata_i,
    .chk_we_i, .chk_wdata_i,
    .clr_o(clr), .act_o(act), .ebytes_o(ebytes), .thr_o(thr), .wm_o(wm_f)
  );

  spi_fifo_store #(.CAP_BYTES(CAP_BYTES)) u_store (
    .clk_i, .rst_ni,
    .clr_i(clr), .act_i(act), .ebytes_i(ebytes),
    .push_i, .push_data_i, .pop_i, .pop_data_o,
    .lvl_o(lvl), .err_o
  );

  spi_fifo_flags #(.CAP_BYTES(CAP_BYTES), .RX_DIR(RX_DIR)) u_flags (
    .lvl_i(lvl), .ebytes_i(ebytes), .thr_i(thr), .wm_i(wm_f),
    .status_o, .thr_o, .wm_o
  );

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(push_i || pop_i)); // R6
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[8] && status_o[9])); // R5
  AST_STOP_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act) |=> !err_o); // R2
endmodule

// File: tb/spi_byte_fifo_test.sv
`timescale 1ns/1ps
module spi_byte_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_we = 0, ctrl_we = 0, chk_we = 0, push = 0, pop = 0;
  logic [1:0]  op_wd = '0;
  logic [9:0]  ctrl_wd = '0;
  logic [25:0] chk_wd = '0;
  logic [31:0] push_d = '0;
  logic [31:0] pop_d, pop_d_tx;
  logic [9:0]  st, st_tx;
  logic        thr, thr_tx, err, err_tx;
  logic [2:0]  wm, wm_tx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_byte_fifo #(.CAP_BYTES(256), .RX_DIR(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .op_we_i(op_we), .op_wdata_i(op_wd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .chk_we_i(chk_we), .chk_wdata_i(chk_wd),
    .push_i(push), .push_data_i(push_d), .pop_i(pop), .pop_data_o(pop_d),
    .status_o(st), .thr_o(thr), .wm_o(wm), .err_o(err));

  spi_byte_fifo #(.CAP_BYTES(256), .RX_DIR(1'b0)) uut_tx (
    .clk_i(clk), .rst_ni(rst_n), .op_we_i(op_we), .op_wdata_i(op_wd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .chk_we_i(chk_we), .chk_wdata_i(chk_wd),
    .push_i(push), .push_data_i(push_d), .pop_i(pop), .pop_data_o(pop_d_tx),
    .status_o(st_tx), .thr_o(thr_tx), .wm_o(wm_tx), .err_o(err_tx));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [1:0] v);
    @(negedge clk); op_we = 1; op_wd = v;
    @(negedge clk); op_we = 0;
  endtask

  task automatic wr_ctrl(input int w, input int t);
    @(negedge clk); ctrl_we = 1; ctrl_wd = {8'(t), 2'(w)};
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic do_io(input logic p, input logic q, input logic [31:0] d);
    @(negedge clk); push = p; pop = q; push_d = d;
    @(negedge clk); push = 0; pop = 0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0F00 ^ (i * 32'h0103_0507);
  endfunction

  function automatic logic [31:0] msk(input int eb);
    return (eb == 1) ? 32'h0000_00FF : (eb == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [9:0] exp_st(input int lvl, input int eb);
    return {(lvl == 0), (lvl > 256 - eb), 8'((lvl > 255) ? 255 : lvl)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int wmf[3];
    wmf[0] = 4; wmf[1] = 32; wmf[2] = 60;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", 32'(st), 32'(exp_st(0, 1)));
    chk("R1 err", 32'(err), 0);

    // R2 push while stopped is ignored
    do_io(1, 0, 32'h11);
    chk("R2 stopped push level", 32'(st), 32'(exp_st(0, 1)));
    chk("R2 stopped push no err", 32'(err), 0);
    wr_op(2'b01);
    do_io(1, 0, 32'h22);
    chk("R2 reset push level", 32'(st), 32'(exp_st(0, 1)));
    wr_op(2'b10);
    do_io(1, 0, 32'h33);
    chk("R2 running push", 32'(st), 32'(exp_st(1, 1)));
    wr_op(2'b00);
    do_io(0, 1, 0);
    chk("R2 stopped pop kept", 32'(st), 32'(exp_st(1, 1)));
    chk("R2 stopped pop no err", 32'(err), 0);
    wr_op(2'b01);
    @(negedge clk);
    chk("R2 flush clears", 32'(st), 32'(exp_st(0, 1)));

    @(negedge clk); chk_we = 1; chk_wd = {6'(wmf[2]), 4'b0, 6'(wmf[1]), 4'b0, 6'(wmf[0])};
    @(negedge clk); chk_we = 0;

    for (int w = 0; w < 4; w++) begin
      int eb, n, t;
      eb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      n = 256 / eb;
      t = 40 + 30 * w;
      wr_op(2'b01); wr_op(2'b10);
      wr_ctrl(w, t);
      for (int i = 0; i < n; i++) begin
        int lv;
        do_io(1, 0, pat(i + w));
        lv = (i + 1) * eb;
        chk($sformatf("R5 status w%0d", w), 32'(st), 32'(exp_st(lv, eb)));
        chk("R7 rx threshold", 32'(thr), 32'(lv >= t));
        chk("R7 tx threshold", 32'(thr_tx), 32'(lv <= t));
        for (int k = 0; k < 3; k++)
          chk("R8 watermark", 32'(wm[k]), 32'((lv / 4) >= wmf[k]));
        chk("R3 no err before full", 32'(err), 0);
      end
      chk($sformatf("R3 full after %0d entries", n), 32'(st[8]), 1);
      do_io(1, 0, 32'hDEAD_BEEF);
      chk("R6 overflow err", 32'(err), 1);
      chk("R6 overflow level kept", 32'(st), 32'(exp_st(256, eb)));
      @(negedge clk);
      chk("R6 err one cycle", 32'(err), 0);
      for (int i = 0; i < n; i++) begin
        chk($sformatf("R4 pop data w%0d", w), pop_d, pat(i + w) & msk(eb));
        do_io(0, 1, 0);
      end
      chk("R5 empty after drain", 32'(st), 32'(exp_st(0, eb)));
      do_io(0, 1, 0);
      chk("R6 underflow err", 32'(err), 1);
      chk("R6 underflow level", 32'(st), 32'(exp_st(0, eb)));
      @(negedge clk);
      chk("R6 underflow err clears", 32'(err), 0);
    end

    // R9 push and pop together
    wr_op(2'b01); wr_op(2'b10);
    wr_ctrl(1, 0);
    do_io(1, 0, 32'h0000_1234);
    do_io(1, 0, 32'h0000_5678);
    chk("R9 pair head", pop_d, 32'h1234);
    do_io(1, 1, 32'hFFFF_9ABC);
    chk("R9 pair level", 32'(st), 32'(exp_st(4, 2)));
    chk("R9 pair no err", 32'(err), 0);
    chk("R9 new head", pop_d, 32'h5678);
    do_io(0, 1, 0);
    chk("R9 tail entry", pop_d, 32'h9ABC);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule